// File: doc/BRIEF.md
# Planar Pixel Format Serializer

The serializer sits at the end of a display refresh path. Once per character clock it loads one 32-bit memory word made of four 8-bit planes, and it then sends out eight pixels on eight consecutive dot clocks. Plane p occupies word bits [8p+7:8p]. A two-bit format input decides how the planes are interleaved into pixels. In the character (text) format, the font glyph byte for the current scan line comes in next to the word, and the block colours each glyph bit from the attribute byte.

A one-cycle load strobe captures the word, the glyph byte and the format together. The pixels come out on the eight cycles that follow. A load in the cycle of the eighth pixel gives an unbroken stream. A load given earlier drops the rest of the current word and starts on the new one. While no word is being serialized, the valid strobe is low and the pixel output is zero.

Top module: `plane_pixel_serializer`

## Requirements
- R1: While reset is asserted, and in every cycle where `pix_valid` is low, `pix_out` is 0 and `pix_valid` is 0.
- R2: A `load` sampled at a clock edge makes `pix_valid` high for the eight cycles after that edge, with pixel index 0..7 in order. If no new load arrives, `pix_valid` then goes low.
- R3: Format 0 (text): plane 1 is the attribute byte. Pixel i is the attribute's bits [3:0] when glyph bit 7-i is set, and bits [7:4] when it is clear. Output bits [7:4] are 0.
- R4: Format 1 (odd/even): for i=0..3, pixel i is {plane2 bits [7-2i:6-2i], plane0 bits [7-2i:6-2i]}. Pixels 4..7 follow the same rule with planes 3 and 1 and with i-4 in place of i. Output bits [7:4] are 0.
- R5: Format 2 (planar): pixel i is {plane3[7-i], plane2[7-i], plane1[7-i], plane0[7-i]}. Output bits [7:4] are 0.
- R6: Format 3 (byte-per-pixel): pixel i is plane i/2 (integer division), so each plane byte is shown for two consecutive dot clocks, in plane order 0, 1, 2, 3.
- R7: `mode_in`, `word_in` and `glyph_in` are sampled only on a load. Changes to them in other cycles do not alter the pixels of the word being serialized.
- R8: A load in the cycle that shows pixel 7 makes pixel 0 of the new word follow with no gap. A load in any earlier cycle drops the remaining pixels and starts the new word on the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Dot clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load | input | 1 | Captures word, glyph and format at this edge |
| word_in | input | 32 | Four 8-bit planes, plane p at bits [8p+7:8p] |
| glyph_in | input | 8 | Font glyph scan-line byte (text format) |
| mode_in | input | 2 | Format: 0 text, 1 odd/even, 2 planar, 3 byte-per-pixel |
| pix_valid | output | 1 | Pixel output holds a pixel |
| pix_out | output | 8 | Pixel value |

## Verification
Two events can fall in the same cycle: the last pixel of one word is being shown while the load for the next word arrives. A load that comes before the eighth pixel is also tested, because it cuts the current word short. Both are provoked by strobes placed exactly eight cycles apart, by strobes placed a few cycles apart, and by random traffic. The cycle-accurate model in the bench judges them by discarding its queue of pending pixels at every load. A missing, repeated or extra pixel at the seam therefore shows up as a mismatch.

// File: rtl/pss_pkg.sv
package pss_pkg;
  typedef enum logic [1:0] {
    FMT_TEXT    = 2'd0,
    FMT_ODDEVEN = 2'd1,
    FMT_PLANAR  = 2'd2,
    FMT_BYTE    = 2'd3
  } fmt_e;

  localparam int NUM_PLANES = 4;
endpackage

// File: rtl/pss_capture.sv
module pss_capture #(
  parameter int PLANE_W = 8,
  localparam int WORD_W = pss_pkg::NUM_PLANES * PLANE_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [WORD_W-1:0]  word_in,
  input  logic [PLANE_W-1:0] glyph_in,
  input  logic [1:0]         mode_in,
  output logic [WORD_W-1:0]  word_q,
  output logic [PLANE_W-1:0] glyph_q,
  output pss_pkg::fmt_e      mode_q
);
  logic [WORD_W-1:0]  word_d;
  logic [PLANE_W-1:0] glyph_d;
  pss_pkg::fmt_e      mode_d;

  always_comb begin
    word_d  = word_q;
    glyph_d = glyph_q;
    mode_d  = mode_q;
    if (load) begin
      word_d  = word_in;
      glyph_d = glyph_in;
      mode_d  = pss_pkg::fmt_e'(mode_in);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q  <= '0;
      glyph_q <= '0;
      mode_q  <= pss_pkg::FMT_TEXT;
    end else begin
      word_q  <= word_d;
      glyph_q <= glyph_d;
      mode_q  <= mode_d;
    end
  end
endmodule

// File: rtl/pss_sequencer.sv
module pss_sequencer #(
  parameter int PLANE_W = 8,
  localparam int CNT_W = $clog2(PLANE_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  output logic             active,
  output logic [CNT_W-1:0] idx
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PLANE_W - 1);

  logic             active_d;
  logic [CNT_W-1:0] idx_d;

  always_comb begin
    active_d = active;
    idx_d    = idx;
    if (load) begin
      active_d = 1'b1;
      idx_d    = '0;
    end else if (active) begin
      if (idx == LAST) begin
        active_d = 1'b0;
        idx_d    = '0;
      end else begin
        idx_d = idx + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      idx    <= '0;
    end else begin
      active <= active_d;
      idx    <= idx_d;
    end
  end
endmodule

// File: rtl/pss_format.sv
module pss_format #(
  parameter int PLANE_W = 8,
  localparam int WORD_W = pss_pkg::NUM_PLANES * PLANE_W,
  localparam int CNT_W  = $clog2(PLANE_W),
  localparam int NIB_W  = pss_pkg::NUM_PLANES
) (
  input  logic [WORD_W-1:0]  word_q,
  input  logic [PLANE_W-1:0] glyph_q,
  input  pss_pkg::fmt_e      mode_q,
  input  logic [CNT_W-1:0]   idx,
  output logic [PLANE_W-1:0] pix
);
  logic [PLANE_W-1:0] plane [pss_pkg::NUM_PLANES];

  for (genvar p = 0; p < pss_pkg::NUM_PLANES; p++) begin : g_split
    assign plane[p] = word_q[p*PLANE_W +: PLANE_W];
  end

  logic [CNT_W-1:0] bit_pos;
  logic [CNT_W-2:0] pair_idx;
  logic [CNT_W-1:0] pair_hi;
  logic [CNT_W-1:0] pair_lo;
  logic             second_half;
  logic [1:0]       byte_sel;
  logic [NIB_W-1:0] attr_fg;
  logic [NIB_W-1:0] attr_bg;
  logic [NIB_W-1:0] planar_nib;

  assign bit_pos     = CNT_W'(PLANE_W - 1) - idx;
  assign second_half = idx[CNT_W-1];
  assign pair_idx    = idx[CNT_W-2:0];
  assign pair_hi     = CNT_W'(PLANE_W - 1) - {pair_idx, 1'b0};
  assign pair_lo     = pair_hi - 1'b1;
  assign byte_sel    = idx[CNT_W-1 -: 2];
  assign attr_fg     = plane[1][NIB_W-1:0];
  assign attr_bg     = plane[1][2*NIB_W-1:NIB_W];

  for (genvar b = 0; b < NIB_W; b++) begin : g_planar
    assign planar_nib[b] = plane[b][bit_pos];
  end

  always_comb begin
    pix = '0;
    unique case (mode_q)
      pss_pkg::FMT_TEXT:
        pix = PLANE_W'(glyph_q[bit_pos] ? attr_fg : attr_bg);
      pss_pkg::FMT_ODDEVEN:
        if (second_half)
          pix = PLANE_W'({plane[3][pair_hi], plane[3][pair_lo],
                          plane[1][pair_hi], plane[1][pair_lo]});
        else
          pix = PLANE_W'({plane[2][pair_hi], plane[2][pair_lo],
                          plane[0][pair_hi], plane[0][pair_lo]});
      pss_pkg::FMT_PLANAR:
        pix = PLANE_W'(planar_nib);
      pss_pkg::FMT_BYTE:
        pix = plane[byte_sel];
      default: pix = '0;
    endcase
  end
endmodule

// File: rtl/plane_pixel_serializer.sv
module plane_pixel_serializer #(
  parameter int PLANE_W = 8,
  localparam int WORD_W = pss_pkg::NUM_PLANES * PLANE_W,
  localparam int CNT_W  = $clog2(PLANE_W)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [WORD_W-1:0]  word_in,
  input  logic [PLANE_W-1:0] glyph_in,
  input  logic [1:0]         mode_in,
  output logic               pix_valid,
  output logic [PLANE_W-1:0] pix_out
);
  logic [WORD_W-1:0]  word_q;
  logic [PLANE_W-1:0] glyph_q;
  pss_pkg::fmt_e      mode_q;
  logic               active;
  logic [CNT_W-1:0]   idx;
  logic [PLANE_W-1:0] fmt_pix;

  pss_capture #(.PLANE_W(PLANE_W)) u_cap (
    .clk(clk), .rst_n(rst_n), .load(load),
    .word_in(word_in), .glyph_in(glyph_in), .mode_in(mode_in),
    .word_q(word_q), .glyph_q(glyph_q), .mode_q(mode_q)
  );

  pss_sequencer #(.PLANE_W(PLANE_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .load(load),
    .active(active), .idx(idx)
  );

  pss_format #(.PLANE_W(PLANE_W)) u_fmt (
    .word_q(word_q), .glyph_q(glyph_q), .mode_q(mode_q),
    .idx(idx), .pix(fmt_pix)
  );

  assign pix_valid = active;
  assign pix_out   = active ? fmt_pix : '0;
endmodule

// File: rtl/pss_checker.sv
module pss_checker #(
  parameter int PLANE_W = 8,
  localparam int CNT_W = $clog2(PLANE_W)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               load,
  input logic [1:0]         mode_in,
  input logic               pix_valid,
  input logic [PLANE_W-1:0] pix_out
);
  logic [CNT_W-1:0] run;
  logic [1:0]       cmode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run   <= '0;
      cmode <= '0;
    end else if (load) begin
      run   <= '0;
      cmode <= mode_in;
    end else if (pix_valid) begin
      run <= run + 1'b1;
    end
  end

  p_idle_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_valid |-> pix_out == '0);

  p_load_starts_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> pix_valid);

  p_run_continues_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && !load && run != CNT_W'(PLANE_W - 1)) |=> pix_valid);

  p_run_ends_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && !load && run == CNT_W'(PLANE_W - 1)) |=> !pix_valid);

  p_nibble_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && cmode != 2'd3) |-> pix_out[PLANE_W-1:PLANE_W/2] == '0);

  p_double_dot_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && !load && cmode == 2'd3 && !run[0]) |=> $stable(pix_out));
endmodule

bind plane_pixel_serializer pss_checker #(.PLANE_W(PLANE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .load(load), .mode_in(mode_in),
  .pix_valid(pix_valid), .pix_out(pix_out)
);

// File: tb/tb_plane_pixel_serializer.sv
module tb_plane_pixel_serializer;
  logic        clk;
  logic        rst_n;
  logic        load;
  logic [31:0] word_in;
  logic [7:0]  glyph_in;
  logic [1:0]  mode_in;
  logic        pix_valid;
  logic [7:0]  pix_out;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [7:0] exp_q[$];
  string      tag_q[$];

  plane_pixel_serializer dut (
    .clk(clk), .rst_n(rst_n), .load(load), .word_in(word_in),
    .glyph_in(glyph_in), .mode_in(mode_in),
    .pix_valid(pix_valid), .pix_out(pix_out)
  );

  initial clk = 0;
  always #4 clk = ~clk;

  function automatic logic [7:0] ref_pixel(int m, logic [31:0] w, logic [7:0] g, int i);
    int r;
    int sh;
    int pa, pb;
    r = 0;
    if (m == 0) begin
      if (g[7-i]) r = w[11:8];
      else        r = w[15:12];
    end else if (m == 1) begin
      if (i < 4) begin pa = w[23:16]; pb = w[7:0];   sh = 6 - 2*i; end
      else       begin pa = w[31:24]; pb = w[15:8];  sh = 6 - 2*(i-4); end
      r = (((pa >> sh) & 3) << 2) | ((pb >> sh) & 3);
    end else if (m == 2) begin
      for (int b = 0; b < 4; b++) r = r | (((w >> (8*b + 7 - i)) & 1) << b);
    end else begin
      r = (w >> (8*(i/2))) & 8'hFF;
    end
    return r[7:0];
  endfunction

  task automatic check(string tag, bit ok, logic [8:0] act, logic [8:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual valid/pix=%h expected=%h at %0t", tag, act, expv, $time);
    end
  endtask

  // Compare outputs of this cycle, then drive the next inputs.
  task automatic step(bit ld, logic [31:0] w, logic [7:0] g, logic [1:0] m, string tag);
    logic [8:0] act;
    logic [8:0] expv;
    @(negedge clk);
    act = {pix_valid, pix_out};
    if (exp_q.size() > 0) begin
      expv = {1'b1, exp_q.pop_front()};
      check(tag_q.pop_front(), act === expv, act, expv);
    end else begin
      expv = 9'h000;
      check("R2", act === expv, act, expv);
    end
    load     = ld;
    word_in  = w;
    glyph_in = g;
    mode_in  = m;
    if (ld) begin
      string t;
      exp_q.delete();
      tag_q.delete();
      for (int i = 0; i < 8; i++) begin
        exp_q.push_back(ref_pixel(m, w, g, i));
        if (tag != "") t = tag;
        else if (m == 0) t = "R3";
        else if (m == 1) t = "R4";
        else if (m == 2) t = "R5";
        else t = "R6";
        tag_q.push_back(t);
      end
    end
  endtask

  initial begin
    #800000;
    fails++;
    checks++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 0; load = 0; word_in = 0; glyph_in = 0; mode_in = 0;
    repeat (3) begin
      @(negedge clk);
      check("R1", {pix_valid, pix_out} === 9'h000, {pix_valid, pix_out}, 9'h000);
    end
    @(negedge clk);
    rst_n = 1;

    // Each format, isolated words with idle gaps
    for (int m = 0; m < 4; m++) begin
      for (int k = 0; k < 3; k++) begin
        step(1, $urandom, $urandom, 2'(m), "");
        repeat (7) step(0, 32'h0, 8'h0, 2'd0, "");
        repeat (2) step(0, 32'h0, 8'h0, 2'd0, "");
      end
    end
    // Fixed patterns
    step(1, 32'h0000_A5_00, 8'hF0, 2'd0, "R3");
    repeat (8) step(0, 0, 0, 0, "");
    step(1, 32'hE4_1B_C6_39, 8'h0, 2'd1, "R4");
    repeat (8) step(0, 0, 0, 0, "");
    step(1, 32'h80_40_20_01, 8'h0, 2'd2, "R5");
    repeat (8) step(0, 0, 0, 0, "");
    step(1, 32'h44_33_22_11, 8'h0, 2'd3, "R6");
    repeat (8) step(0, 0, 0, 0, "");

    // R8 seamless: load on the cycle showing pixel 7
    for (int k = 0; k < 6; k++) begin
      step(1, $urandom, $urandom, 2'($urandom), "R8");
      repeat (7) step(0, 0, 0, 0, "");
    end
    repeat (9) step(0, 0, 0, 0, "");

    // R8 restart: early reloads
    for (int k = 1; k < 7; k++) begin
      step(1, $urandom, $urandom, 2'($urandom), "R8");
      repeat (k) step(0, 0, 0, 0, "");
    end
    repeat (9) step(0, 0, 0, 0, "");

    // R7: inputs change between loads
    for (int k = 0; k < 8; k++) begin
      step(1, $urandom, $urandom, 2'(k % 4), "R7");
      repeat (7) step(0, $urandom, $urandom, 2'($urandom), "");
      step(0, $urandom, $urandom, 2'($urandom), "");
    end

    // Random traffic
    for (int k = 0; k < 600; k++)
      step(($urandom % 6) == 0, $urandom, $urandom, 2'($urandom), "");
    repeat (10) step(0, 0, 0, 0, "");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule